// File: doc/BRIEF.md
# Multi-Port ADC Sweep Sequencer

This block decides which of a set of analog ports (20 by default) a shared converter samples next. It averages the samples of each port and keeps one 12-bit result register per port. A port takes part only when its bit in the enable mask is set. The converter is seen as a plain handshake: the sequencer puts a port number on `port_sel_o` and pulses `conv_start_o`. The converter later answers with `conv_done_i` and a sample value.

A 2-bit mode input selects how conversions are triggered. The modes are: off, one full pass over the enabled ports per trigger, one port per trigger, or free-running passes that need no trigger. Each port has its own 3-bit averaging exponent N. The port's result register is refreshed only after 2^N samples have been collected, so a port averaging over many samples refreshes only once every several passes. A host read strobe per port marks the result as consumed. When a result is overwritten before the host has read it, the block reports it with a pulse.

Top module: `adc_sweep_seq`

## Requirements
- R1: After reset every result field of `data_o` is zero, and `conv_start_o`, `cmpl_o`, `drdy_o` and `dmiss_o` are low.
- R2: With `mode_i` = 0 no conversion is started and `cmpl_o` never pulses, whatever `trig_i` does.
- R3: With `mode_i` = 1, a one-cycle `trig_i` pulse makes one conversion of each enabled port, in ascending port order. The sequencer then stops until the next trigger.
- R4: With `mode_i` = 2, each trigger converts exactly one port. The first trigger after reset takes the lowest enabled port. Each later trigger takes the next higher enabled port after the one last converted, and after the highest enabled port it wraps back to the lowest.
- R5: With `mode_i` = 3 the sequencer repeats passes over the enabled ports in ascending order without any trigger, and `cmpl_o` pulses once per pass.
- R6: While no port is enabled, triggers start no conversion.
- R7: Port p's averaging exponent N is `avg_exp_i[3p+2:3p]` (0..7). Its result becomes the sum of its last 2^N samples shifted right by N. Passes or conversions that end before the 2^N-th sample leave the result unchanged and raise no `drdy_o`.
- R8: Port p's result is `data_o[12p+11:12p]`. Results are written at the end of a pass (modes 1 and 3) or at the end of each conversion (mode 2). `cmpl_o` and `drdy_o` pulse for one cycle, in the same cycle the new result appears, and `data_o` changes in no other cycle.
- R9: `conv_start_o` is a one-cycle pulse. `port_sel_o` holds the converted port's index from that pulse until `conv_done_i` is accepted.
- R10: `dmiss_o` pulses when a result is overwritten while it is still unread. A result counts as unread from its write until a `host_rd_i[p]` strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Trigger mode: 0 off, 1 one pass, 2 one port, 3 free-running |
| port_en_i | input | NPORT | Per-port enable mask |
| avg_exp_i | input | NPORT*3 | Per-port averaging exponents |
| trig_i | input | 1 | Conversion trigger strobe |
| host_rd_i | input | NPORT | Per-port host read strobe |
| conv_done_i | input | 1 | Converter finished, sample valid |
| conv_sample_i | input | 12 | Converter sample value |
| conv_start_o | output | 1 | Start pulse to the converter |
| port_sel_o | output | 5 | Port being converted |
| data_o | output | NPORT*12 | Per-port averaged results |
| cmpl_o | output | 1 | Pass or conversion complete pulse |
| drdy_o | output | 1 | Some result refreshed pulse |
| dmiss_o | output | 1 | Unread result overwritten pulse |

## Verification
The hardest state to reach from the ports is a port whose average spans several passes. Its partial sum and count must survive commits that write nothing, and the final commit must land in the same cycle as the last sample. The bench reaches this state with one enabled port at exponent 2. It runs four single passes with different sample values and checks that the result and `drdy_o` stay quiet until the fourth pass. The overrun case needs a result left unread on purpose across later passes: the bench overwrites one port without a read, then reads it and overwrites it again.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_SWEEP = 2'd1,
    MODE_STEP  = 2'd2,
    MODE_CONT  = 2'd3
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_seq_pick.sv
// Priority finder: lowest enabled port whose index is at or above from_idx.
module adc_seq_pick #(
  parameter int NPORT = 20,
  parameter int PW    = 5
) (
  input  logic [NPORT-1:0] mask_i,
  input  logic [PW-1:0]    from_idx_i,
  output logic             found_o,
  output logic [PW-1:0]    idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (mask_i[i] && (PW'(i) >= from_idx_i)) begin
        found_o = 1'b1;
        idx_o   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Scheduler: chooses the port, runs the converter handshake, marks commits.
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NPORT = 20,
  parameter int PW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [NPORT-1:0] port_en_i,
  input  logic             trig_i,
  input  logic             conv_done_i,
  output logic             conv_start_o,
  output logic [PW-1:0]    port_sel_o,
  output logic             smp_vld_o,
  output logic             commit_o
);
  seq_state_e     state_q, state_d;
  logic [PW-1:0]  ptr_q, ptr_d;
  logic [PW-1:0]  step_q, step_d;
  logic           sweep_q, sweep_d;
  logic           state_en;

  logic           lo_found, nx_found, st_found;
  logic [PW-1:0]  lo_idx, nx_idx, st_idx;
  logic [PW-1:0]  nx_from;

  assign nx_from = ptr_q + PW'(1);

  adc_seq_pick #(.NPORT(NPORT), .PW(PW)) u_pick_lo (
    .mask_i(port_en_i), .from_idx_i('0), .found_o(lo_found), .idx_o(lo_idx));
  adc_seq_pick #(.NPORT(NPORT), .PW(PW)) u_pick_nx (
    .mask_i(port_en_i), .from_idx_i(nx_from), .found_o(nx_found), .idx_o(nx_idx));
  adc_seq_pick #(.NPORT(NPORT), .PW(PW)) u_pick_st (
    .mask_i(port_en_i), .from_idx_i(step_q), .found_o(st_found), .idx_o(st_idx));

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    step_d    = step_q;
    sweep_d   = sweep_q;
    smp_vld_o = 1'b0;
    commit_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (lo_found) begin
          if ((mode_i == MODE_CONT) || ((mode_i == MODE_SWEEP) && trig_i)) begin
            ptr_d   = lo_idx;
            sweep_d = 1'b1;
            state_d = ST_ISSUE;
          end else if ((mode_i == MODE_STEP) && trig_i) begin
            ptr_d   = st_found ? st_idx : lo_idx;
            sweep_d = 1'b0;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (conv_done_i) begin
          smp_vld_o = 1'b1;
          if (sweep_q && nx_found) begin
            ptr_d   = nx_idx;
            state_d = ST_ISSUE;
          end else begin
            commit_o = (mode_i != MODE_IDLE);
            state_d  = ST_IDLE;
            if (!sweep_q) step_d = nx_from;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q) || (ptr_d != ptr_q) ||
                    (step_d != step_q) || (sweep_d != sweep_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      step_q  <= '0;
      sweep_q <= 1'b0;
    end else if (state_en) begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      step_q  <= step_d;
      sweep_q <= sweep_d;
    end
  end

  assign conv_start_o = (state_q == ST_ISSUE);
  assign port_sel_o   = ptr_q;

  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);
  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !conv_done_i) |=> $stable(port_sel_o));
  assert_sweep_ascends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && conv_done_i && sweep_q && nx_found) |=> (port_sel_o > $past(port_sel_o)));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && mode_i == MODE_IDLE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/adc_seq_bank.sv
// Per-port accumulators, result registers and unread tracking.
module adc_seq_bank #(
  parameter int NPORT = 20,
  parameter int DW    = 12,
  parameter int EW    = 3,
  parameter int PW    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT*EW-1:0] avg_exp_i,
  input  logic                smp_vld_i,
  input  logic [PW-1:0]       smp_port_i,
  input  logic [DW-1:0]       smp_val_i,
  input  logic                commit_i,
  input  logic [NPORT-1:0]    host_rd_i,
  output logic [NPORT*DW-1:0] data_o,
  output logic                cmpl_o,
  output logic                drdy_o,
  output logic                dmiss_o
);
  localparam int MAXEXP = (1 << EW) - 1;
  localparam int ACCW   = DW + MAXEXP;
  localparam int CW     = MAXEXP + 1;
  localparam logic [CW-1:0] CMAX = CW'(1) << MAXEXP;

  logic [NPORT-1:0] wr_v, miss_v;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic [ACCW-1:0] acc_q, acc_u, acc_d;
    logic [CW-1:0]   cnt_q, cnt_u, cnt_d;
    logic [DW-1:0]   dat_q, dat_d;
    logic            unr_q, unr_d;
    logic [EW-1:0]   exp_w;
    logic [CW-1:0]   target;
    logic            hit, wr, upd_en;

    assign exp_w  = avg_exp_i[g*EW +: EW];
    assign target = CW'(1) << exp_w;
    assign hit    = smp_vld_i && (smp_port_i == PW'(g));

    always_comb begin
      acc_u = acc_q;
      cnt_u = cnt_q;
      if (hit && (cnt_q < target)) begin
        acc_u = acc_q + ACCW'(smp_val_i);
        cnt_u = cnt_q + CW'(1);
      end
      wr    = commit_i && (cnt_u >= target);
      dat_d = wr ? DW'(acc_u >> exp_w) : dat_q;
      acc_d = wr ? '0 : acc_u;
      cnt_d = wr ? '0 : cnt_u;
      unr_d = wr | (unr_q & ~host_rd_i[g]);
    end

    assign upd_en = hit || wr || host_rd_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
        cnt_q <= '0;
        dat_q <= '0;
        unr_q <= 1'b0;
      end else if (upd_en) begin
        acc_q <= acc_d;
        cnt_q <= cnt_d;
        dat_q <= dat_d;
        unr_q <= unr_d;
      end
    end

    assign wr_v[g]   = wr;
    assign miss_v[g] = wr & unr_q & ~host_rd_i[g];
    assign data_o[g*DW +: DW] = dat_q;

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CMAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpl_o  <= 1'b0;
      drdy_o  <= 1'b0;
      dmiss_o <= 1'b0;
    end else begin
      cmpl_o  <= commit_i;
      drdy_o  <= |wr_v;
      dmiss_o <= |miss_v;
    end
  end
endmodule

// File: rtl/adc_sweep_seq.sv
module adc_sweep_seq
  import adc_seq_pkg::*;
#(
  parameter int NPORT = 20,
  parameter int DW    = 12,
  parameter int EW    = 3,
  localparam int PW   = $clog2(NPORT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic [NPORT-1:0]    port_en_i,
  input  logic [NPORT*EW-1:0] avg_exp_i,
  input  logic                trig_i,
  input  logic [NPORT-1:0]    host_rd_i,
  input  logic                conv_done_i,
  input  logic [DW-1:0]       conv_sample_i,
  output logic                conv_start_o,
  output logic [PW-1:0]       port_sel_o,
  output logic [NPORT*DW-1:0] data_o,
  output logic                cmpl_o,
  output logic                drdy_o,
  output logic                dmiss_o
);
  logic smp_vld, commit;

  adc_seq_ctrl #(.NPORT(NPORT), .PW(PW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .port_en_i   (port_en_i),
    .trig_i      (trig_i),
    .conv_done_i (conv_done_i),
    .conv_start_o(conv_start_o),
    .port_sel_o  (port_sel_o),
    .smp_vld_o   (smp_vld),
    .commit_o    (commit)
  );

  adc_seq_bank #(.NPORT(NPORT), .DW(DW), .EW(EW), .PW(PW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .avg_exp_i (avg_exp_i),
    .smp_vld_i (smp_vld),
    .smp_port_i(port_sel_o),
    .smp_val_i (conv_sample_i),
    .commit_i  (commit),
    .host_rd_i (host_rd_i),
    .data_o    (data_o),
    .cmpl_o    (cmpl_o),
    .drdy_o    (drdy_o),
    .dmiss_o   (dmiss_o)
  );

  assert_no_idle_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_o |-> ($past(mode_i) != MODE_IDLE));
  assert_data_only_on_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !drdy_o |-> $stable(data_o));
endmodule

// File: tb/adc_sweep_seq_bench.sv
module adc_sweep_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic [NP-1:0] en;
  logic [NP*3-1:0] aexp;
  logic          trig;
  logic [NP-1:0] hrd;
  logic          cdone;
  logic [11:0]   csmp;
  logic          cstart;
  logic [4:0]    psel;
  logic [NP*12-1:0] dout;
  logic          cmpl, drdy, dmiss;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_sweep_seq u_adc_sweep_seq (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .port_en_i(en), .avg_exp_i(aexp),
    .trig_i(trig), .host_rd_i(hrd), .conv_done_i(cdone), .conv_sample_i(csmp),
    .conv_start_o(cstart), .port_sel_o(psel), .data_o(dout),
    .cmpl_o(cmpl), .drdy_o(drdy), .dmiss_o(dmiss));

  int n_chk = 0, n_fail = 0;
  int n_cmpl = 0, n_drdy = 0, n_miss = 0, n_conv = 0;
  bit finished = 0;
  logic [11:0] smp_val [NP];
  int exp_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int port_data(input int p);
    return int'(dout[p*12 +: 12]);
  endfunction

  // Converter model and scoreboard monitor: pops the expected port order.
  initial begin
    cdone = 1'b0;
    csmp  = '0;
    @(negedge clk);
    forever begin
      if (rst_n && cstart) begin
        int p;
        p = int'(psel);
        n_conv++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2/R3 unexpected conversion", p, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(p == e, "R3 conversion order", p, e);
        end
        repeat (2) @(negedge clk);
        chk(int'(psel) == p, "R9 select held", int'(psel), p);
        csmp  = smp_val[p];
        cdone = 1'b1;
        @(negedge clk);
        cdone = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmpl)  n_cmpl++;
      if (drdy)  n_drdy++;
      if (dmiss) n_miss++;
    end
  end

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_cmpl(input int k);
    int seen = 0;
    for (int t = 0; t < 3000 && seen < k; t++) begin
      @(negedge clk);
      if (cmpl) seen++;
    end
    chk(seen == k, "R8 completion pulses seen", seen, k);
  endtask

  task automatic set_exp(input int p, input int n);
    aexp[p*3 +: 3] = 3'(n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int c0, d0, m0, v0;
    rst_n = 1'b0; mode = 2'd0; en = '0; aexp = '0; trig = 1'b0; hrd = '0;
    for (int i = 0; i < NP; i++) smp_val[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dout == '0, "R1 data zero", int'(dout[11:0]), 0);
    chk(!cstart && !cmpl && !drdy && !dmiss, "R1 outputs low", int'({cstart, cmpl, drdy, dmiss}), 0);

    // R2 idle mode ignores triggers
    en = '1; c0 = n_cmpl; v0 = n_conv;
    pulse_trig(); pulse_trig();
    repeat (20) @(negedge clk);
    chk(n_conv == v0, "R2 no conversion in mode 0", n_conv - v0, 0);
    chk(n_cmpl == c0, "R2 no flag in mode 0", n_cmpl - c0, 0);

    // R3 single pass over ports 2,5,19
    en = '0; en[2] = 1; en[5] = 1; en[19] = 1;
    smp_val[2] = 100; smp_val[5] = 200; smp_val[19] = 300;
    mode = 2'd1; c0 = n_cmpl; d0 = n_drdy;
    exp_q.push_back(2); exp_q.push_back(5); exp_q.push_back(19);
    pulse_trig();
    wait_cmpl(1);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all ports converted", exp_q.size(), 0);
    chk(port_data(2) == 100, "R3 port 2 result", port_data(2), 100);
    chk(port_data(5) == 200, "R3 port 5 result", port_data(5), 200);
    chk(port_data(19) == 300, "R3 port 19 result", port_data(19), 300);
    chk(n_drdy - d0 == 1, "R8 one refresh per pass", n_drdy - d0, 1);
    chk(n_cmpl - c0 == 1, "R3 stops after one pass", n_cmpl - c0, 1);

    // R4 one port per trigger with wrap
    en = '0; en[3] = 1; en[7] = 1;
    smp_val[3] = 33; smp_val[7] = 77;
    mode = 2'd2;
    exp_q.push_back(3); pulse_trig(); wait_cmpl(1);
    @(negedge clk);
    chk(port_data(3) == 33, "R4 first trigger takes lowest", port_data(3), 33);
    chk(port_data(7) == 0, "R4 only one port per trigger", port_data(7), 0);
    exp_q.push_back(7); pulse_trig(); wait_cmpl(1);
    @(negedge clk);
    chk(port_data(7) == 77, "R4 advance to next port", port_data(7), 77);
    smp_val[3] = 34;
    exp_q.push_back(3); pulse_trig(); wait_cmpl(1);
    @(negedge clk);
    chk(port_data(3) == 34, "R4 wrap to lowest", port_data(3), 34);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);

    // R6 no port enabled
    en = '0; v0 = n_conv; c0 = n_cmpl;
    pulse_trig(); mode = 2'd1; pulse_trig();
    repeat (20) @(negedge clk);
    chk(n_conv == v0, "R6 no conversion without enabled port", n_conv - v0, 0);
    chk(n_cmpl == c0, "R6 no flag without enabled port", n_cmpl - c0, 0);

    // R7 port 1 averages 4 samples across 4 passes
    en = '0; en[1] = 1; set_exp(1, 2); mode = 2'd1;
    for (int s = 0; s < 4; s++) begin
      d0 = n_drdy;
      smp_val[1] = (s == 3) ? 12'd41 : 12'((s + 1) * 10);
      exp_q.push_back(1); pulse_trig(); wait_cmpl(1);
      repeat (3) @(negedge clk);
      if (s < 3) begin
        chk(port_data(1) == 0, "R7 result held before 2^N samples", port_data(1), 0);
        chk(n_drdy == d0, "R7 no ready before 2^N samples", n_drdy - d0, 0);
      end else begin
        chk(port_data(1) == 25, "R7 averaged result", port_data(1), 25);
        chk(n_drdy - d0 == 1, "R7 ready on 2^N-th sample", n_drdy - d0, 1);
      end
    end

    // R10 overwrite of unread port 2
    en = '0; en[2] = 1; smp_val[2] = 111; m0 = n_miss;
    exp_q.push_back(2); pulse_trig(); wait_cmpl(1);
    repeat (3) @(negedge clk);
    chk(n_miss - m0 == 1, "R10 missed pulse on unread overwrite", n_miss - m0, 1);
    chk(port_data(2) == 111, "R10 overwritten value", port_data(2), 111);
    hrd[2] = 1'b1; @(negedge clk); hrd[2] = 1'b0;
    smp_val[2] = 112; m0 = n_miss;
    exp_q.push_back(2); pulse_trig(); wait_cmpl(1);
    repeat (3) @(negedge clk);
    chk(n_miss == m0, "R10 no missed pulse after read", n_miss - m0, 0);
    chk(port_data(2) == 112, "R10 value after read", port_data(2), 112);

    // R5 free-running passes over ports 0 and 4, no trigger
    en = '0; en[0] = 1; en[4] = 1; smp_val[0] = 5; smp_val[4] = 9;
    for (int k = 0; k < 3; k++) begin exp_q.push_back(0); exp_q.push_back(4); end
    c0 = n_cmpl;
    mode = 2'd3;
    wait_cmpl(3);
    mode = 2'd0;
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R5 passes ran without trigger", exp_q.size(), 0);
    chk(n_cmpl - c0 == 3, "R5 one flag per pass", n_cmpl - c0, 3);
    chk(port_data(0) == 5, "R5 port 0 result", port_data(0), 5);
    chk(port_data(4) == 9, "R5 port 4 result", port_data(4), 9);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule